// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switch

This block picks one of two running source clocks and passes it to a single gated clock output. The two sources must have frequencies that are integer multiples of each other. The switch can change source while both clocks are running. No glitch appears on the output, and no high or low phase is cut short.

Each source has its own enable flop, clocked on that source's falling edge. A source's enable may rise only after every other enable has dropped, so the switch always breaks the old source before it makes the new one. Between the two events the output rests low.

The output itself is an AND-OR of each source with its enable. Reset clears every enable. Because of that, a source that is not toggling at startup cannot block selection of a source that is.

Top module: `clk_glitchless_sw`

## Requirements
- R1: With `sel` = 0 and the switch settled, `gclk_o` follows `src_clk[0]`, and every high phase is a full high phase of that source.
- R2: With `sel` = 1 and the switch settled, `gclk_o` follows `src_clk[1]`, and every high phase is a full high phase of that source.
- R3: Each enable is sampled only on its own source's falling edge. A selected source with no other source enabled becomes enabled at its next falling edge. No output high phase is shorter than a full source high phase, and no low phase is shorter than the shortest source low phase.
- R4: A source's enable never rises at a falling edge where another source's enable is still set. If `sel` returns to the old source before the new one has taken over, the old source comes back at its next falling edge, and the other source never appears on the output.
- R5: After `sel` changes from 0 to 1, the output's last falling edge is the first falling edge of `src_clk[0]` after the change. The next output rise is the rise of `src_clk[1]` that follows its first falling edge after that.
- R6: After `sel` changes from 1 to 0, the output's last falling edge is the first falling edge of `src_clk[1]` after the change. The next output rise is the rise of `src_clk[0]` that follows its first falling edge after that.
- R7: While `rst_n` is low, both enables are clear and `gclk_o` stays low even though the sources toggle.
- R8: With `src_clk[1]` stopped from reset, `sel` = 0 still brings `src_clk[0]` to the output. The first rise comes at the `src_clk[0]` rise that follows its first falling edge after reset release.
- R9: Both enables are never set at the same time. Between the old source's release and the new source's first rise, `gclk_o` stays low.
- R10: An enabled source that is no longer selected is released at its next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | NSRC (2) | Source clocks. Index 0 is chosen by `sel` = 0 and index 1 by `sel` = 1. |
| rst_n | input | 1 | Active-low asynchronous reset. Clears all enables. |
| sel | input | SELW (1) | Index of the wanted source. Launched from a source domain, away from the falling edges. |
| gclk_o | output | 1 | Gated output clock. |

## Verification
On every falling edge of each source, the embedded assertions check four things: that the enables are mutually exclusive, that an enable waits for the others to clear, that a deselected source drops at once, and that a free, selected source is taken at once.

Some properties relate the output clock to absolute edge times of both sources, and only the bench scenarios can show them. These are:
- the exact output fall and rise times around each switch direction;
- the aborted switch;
- startup with one source stopped;
- the full width of every output phase.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

   // Width of a source index for a given source count (count >= 2).
   function automatic int unsigned idx_w(input int unsigned n);
      return $clog2(n);
   endfunction

endpackage

// File: rtl/clksw_en_cell.sv
module clksw_en_cell #(
   parameter int NSRC = 2,
   parameter int IDX  = 0,
   parameter int SELW = 1
) (
   input  logic            src_clk,
   input  logic            rst_n,
   input  logic [SELW-1:0] sel,
   input  logic [NSRC-1:0] en_all,
   output logic            en_q
);

   localparam logic [SELW-1:0] MY_CODE    = SELW'(IDX);
   localparam logic [NSRC-1:0] OTHER_MASK = ~(NSRC'(1) << IDX);

   logic others_busy;
   logic wanted;
   logic en_d;

   always_comb begin
      others_busy = |(en_all & OTHER_MASK);
      wanted      = (sel == MY_CODE);
      en_d        = wanted & ~others_busy;
   end

   // Falling-edge capture: the enable only moves while this source is low.
   always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_d;
   end

   AST_WAIT_FOR_RELEASE: assert property (@(negedge src_clk) disable iff (!rst_n)
      (!en_q && ((en_all & OTHER_MASK) != '0)) |=> !en_q); // R4

   AST_DROP_ON_FALL: assert property (@(negedge src_clk) disable iff (!rst_n)
      (en_q && (sel != MY_CODE)) |=> !en_q); // R10

   AST_TAKE_WHEN_FREE: assert property (@(negedge src_clk) disable iff (!rst_n)
      ((sel == MY_CODE) && ((en_all & OTHER_MASK) == '0)) |=> en_q); // R3

endmodule

// File: rtl/clksw_gate.sv
module clksw_gate #(
   parameter int NSRC = 2
) (
   input  logic [NSRC-1:0] src_clk,
   input  logic [NSRC-1:0] en,
   output logic            gclk
);

   logic [NSRC-1:0] gated;

   for (genvar i = 0; i < NSRC; i++) begin : g_and
      assign gated[i] = src_clk[i] & en[i];
   end

   assign gclk = |gated;

endmodule

// File: rtl/clk_glitchless_sw.sv
module clk_glitchless_sw #(
   parameter int NSRC = 2,
   parameter int SELW = clksw_pkg::idx_w(NSRC)
) (
   input  logic [NSRC-1:0] src_clk,
   input  logic            rst_n,
   input  logic [SELW-1:0] sel,
   output logic            gclk_o
);

   if (NSRC < 2) begin : g_bad_count
      $error("clk_glitchless_sw: NSRC must be at least 2");
   end
   if (SELW < clksw_pkg::idx_w(NSRC)) begin : g_bad_selw
      $error("clk_glitchless_sw: SELW too narrow for NSRC");
   end

   logic [NSRC-1:0] en_bus;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      clksw_en_cell #(
         .NSRC (NSRC),
         .IDX  (i),
         .SELW (SELW)
      ) u_cell (
         .src_clk (src_clk[i]),
         .rst_n   (rst_n),
         .sel     (sel),
         .en_all  (en_bus),
         .en_q    (en_bus[i])
      );

      AST_ONE_SOURCE: assert property (@(negedge src_clk[i]) disable iff (!rst_n)
         $onehot0(en_bus)); // R9
   end

   clksw_gate #(.NSRC(NSRC)) u_gate (
      .src_clk (src_clk),
      .en      (en_bus),
      .gclk    (gclk_o)
   );

endmodule

// File: tb/clk_glitchless_sw_test.sv
`timescale 1ns/1ps
module clk_glitchless_sw_test;

   localparam realtime HALF0 = 5.0;
   localparam realtime HALF1 = 20.0;
   localparam realtime TOL   = 0.001;

   logic       c0 = 1'b0;
   logic       s1_raw = 1'b0;
   logic       run1 = 1'b0;
   logic       rst_n = 1'b1;
   logic [0:0] sel = 1'b0;
   logic [1:0] src_clk;
   logic       gclk_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;
   bit have_rise = 1'b0;
   bit have_fall = 1'b0;
   realtime last_rise, last_fall;
   realtime exp_q[$];

   assign src_clk = {s1_raw & run1, c0};

   clk_glitchless_sw uut (
      .src_clk (src_clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .gclk_o  (gclk_o)
   );

   // Source 0: 100 MHz, rises at 5 mod 10, falls at 0 mod 10.
   initial forever #5 c0 = ~c0;
   // Source 1: quarter rate, rises at 2.5 mod 40, falls at 22.5 mod 40.
   initial begin
      #2.5;
      forever begin
         s1_raw = ~s1_raw;
         #20;
      end
   end

   function automatic realtime absr(input realtime v);
      return (v < 0.0) ? -v : v;
   endfunction

   // First edge strictly after t with the given phase and period.
   function automatic realtime next_edge(input realtime t, input realtime ph,
                                         input realtime per);
      int n;
      n = int'($floor((t - ph) / per)) + 1;
      return ph + n * per;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input realtime act, input realtime exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
      end
   endtask

   task automatic expect_pulses(input realtime w, input int n);
      for (int k = 0; k < n; k++) exp_q.push_back(w);
      while (exp_q.size() != 0) @(posedge c0);
   endtask

   task automatic wait_until(input realtime t);
      if (t > $realtime) #(t - $realtime);
   endtask

   // Monitor: pops expected high widths, checks every phase for full width.
   initial begin
      realtime w, e;
      forever begin
         @(posedge gclk_o or negedge gclk_o);
         if (!mon_on) continue;
         if (gclk_o) begin
            if (have_fall)
               check(($realtime - last_fall) >= HALF0 - TOL, "R3", "low phase width",
                     $realtime - last_fall, HALF0);
            last_rise = $realtime;
            have_rise = 1'b1;
         end else begin
            if (have_rise) begin
               w = $realtime - last_rise;
               if (exp_q.size() > 0) begin
                  e = exp_q.pop_front();
                  if (absr(e - HALF0) < TOL)
                     check(absr(w - e) < TOL, "R1", "src0 high width", w, e);
                  else
                     check(absr(w - e) < TOL, "R2", "src1 high width", w, e);
               end else begin
                  check((absr(w - HALF0) < TOL) || (absr(w - HALF1) < TOL), "R3",
                        "unchopped high width", w, HALF0);
               end
            end
            last_fall = $realtime;
            have_fall = 1'b1;
         end
      end
   end

   // Driver
   initial begin
      realtime t, f, s, r;
      #1 rst_n = 1'b0;
      // R7: output quiet during reset while source 0 toggles.
      for (int k = 0; k < 3; k++) begin
         @(posedge c0);
         #1;
         check(gclk_o == 1'b0, "R7", "output during reset", gclk_o, 0);
      end
      // R8: release with source 1 stopped.
      @(posedge c0);
      #2;
      t = $realtime;
      rst_n = 1'b1;
      mon_on = 1'b1;
      r = next_edge(t, 0.0, 10.0) + HALF0;
      @(posedge gclk_o);
      check(absr($realtime - r) < TOL, "R8", "first rise with src1 stopped", $realtime, r);
      expect_pulses(HALF0, 6);

      // Start source 1 in its low phase.
      @(negedge s1_raw);
      run1 = 1'b1;
      #100;

      // R5: switch 0 -> 1 while output is high.
      @(posedge c0);
      #2;
      t = $realtime;
      sel = 1'b1;
      f = next_edge(t, 0.0, 10.0);
      s = next_edge(f, 22.5, 40.0);
      r = s + HALF1;
      wait_until(f + 0.5);
      check(absr(last_fall - f) < TOL, "R5", "release time of src0", last_fall, f);
      @(posedge gclk_o);
      check(absr($realtime - r) < TOL, "R5", "first src1 rise", $realtime, r);
      expect_pulses(HALF1, 4);

      // R6: switch 1 -> 0 while output is high.
      @(posedge src_clk[1]);
      #3;
      t = $realtime;
      sel = 1'b0;
      f = next_edge(t, 22.5, 40.0);
      r = next_edge(f, 0.0, 10.0) + HALF0;
      wait_until(f + 0.5);
      check(absr(last_fall - f) < TOL, "R6", "release time of src1", last_fall, f);
      @(posedge gclk_o);
      check(absr($realtime - r) < TOL, "R6", "first src0 rise", $realtime, r);
      expect_pulses(HALF0, 5);

      // R10 / R9: switch 0 -> 1 issued while output is low.
      @(negedge c0);
      #2;
      t = $realtime;
      sel = 1'b1;
      f = next_edge(t, 0.0, 10.0);
      s = next_edge(f, 22.5, 40.0);
      r = s + HALF1;
      wait_until(f + 0.5);
      check(absr(last_fall - f) < TOL, "R10", "deselected src0 dropped", last_fall, f);
      @(posedge gclk_o);
      check(absr($realtime - r) < TOL, "R9", "output low through gap", $realtime, r);
      expect_pulses(HALF1, 3);

      // R4: aborted switch 1 -> 0 -> 1; src0 must never appear.
      @(posedge src_clk[1]);
      #3;
      t = $realtime;
      sel = 1'b0;
      f = next_edge(t, 22.5, 40.0);
      wait_until(f + 1.0);
      sel = 1'b1;
      check(absr(last_fall - f) < TOL, "R4", "release before abort", last_fall, f);
      r = f + 40.0 + HALF1;
      @(posedge gclk_o);
      check(absr($realtime - r) < TOL, "R4", "src1 back after abort", $realtime, r);
      expect_pulses(HALF1, 2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   // Watchdog
   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule